// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block decides, for every transaction seen by a two-sided bus bridge, whether the bridge claims it and passes it to the other side. A transaction arrives with its address, a direction flag and a memory-or-I/O flag. Downstream means from the primary (host) side toward the secondary side. Upstream means the reverse.

The decision rests on three things:
- a 64-bit memory window, held as a 1 MB-granular base and limit split into low and high parts;
- three command enables;
- a legacy display enable, which carves out the classic display frame buffer and the display I/O ports.

The result is registered and appears one cycle after the address strobe. A small register write port loads the configuration.

Top module: `bfwd_decoder`

## Requirements
- R1: After reset, no enable is set and the window is disabled: base is FFFF_FFFF_FFF0_0000h and limit is 0000_0000_000F_FFFFh. No transaction is forwarded until configuration is written.
- R2: When `txn_valid` is high in a cycle, `dec_valid` is high in the next cycle and `dec_forward` holds that cycle's decision. When `txn_valid` is low, both outputs are low in the next cycle.
- R3: A write with `wr_en` high loads the register chosen by `wr_sel`, and takes effect from the next cycle. The selector codes are:
  - 0 is the command register: bit 0 I/O enable, bit 1 memory enable, bit 2 master enable.
  - 1 is bridge control: bit 3 legacy display enable.
  - 2 is base low: bits [11:0] are address bits [31:20].
  - 3 is limit low: bits [11:0] are address bits [31:20].
  - 4 is base high: address bits [63:32].
  - 5 is limit high: address bits [63:32].
- R4: The window spans base {base_hi, base_lo, 20'h00000} through limit {limit_hi, limit_lo, 20'hFFFFF}, inclusive at both ends, and is compared over all 64 bits.
- R5: When the full 64-bit base is greater than the full 64-bit limit, the window matches no address.
- R6: A downstream memory access outside the legacy frame buffer carve-out is forwarded exactly when it lies inside the window and memory enable is set.
- R7: An upstream memory access outside the legacy frame buffer carve-out is forwarded exactly when it lies outside the window and master enable is set.
- R8: With legacy display enable set, the following are forwarded whatever the window holds:
  - a downstream memory access to 000A_0000h–000B_FFFFh, when memory enable is set;
  - a downstream I/O access to a display port, when I/O enable is set.
- R9: With legacy display enable set, an upstream memory access to 000A_0000h–000B_FFFFh is never forwarded.
- R10: A display I/O port is an address whose bits [9:0] fall in 3B0h–3BBh or 3C0h–3DFh and whose bits [63:16] are zero. Bits [15:10] are ignored.
- R11: A display I/O port is never forwarded upstream. Any other upstream I/O access is forwarded when master enable is set. A downstream I/O access that is not a display port, or that arrives with legacy display enable clear, is never forwarded.
- R12: With legacy display enable clear, a memory access to 000A_0000h–000B_FFFFh follows the window rules of R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Register selector for the write |
| wr_data | input | 32 | Configuration write data |
| txn_valid | input | 1 | Transaction address strobe |
| txn_dir | input | 1 | 0 = downstream, 1 = upstream |
| txn_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| txn_addr | input | 64 | Transaction address |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_forward | output | 1 | Claim and forward the transaction |

## Verification
The bench builds the decoder with its default widths. These are a 64-bit address, a 20-bit implied granule, a 12-bit low field and a 32-bit high field, so the full-width compare and the high/low split are exercised as they are used.

The bench sweeps all sixteen combinations of the three command enables and the display enable. It crosses them with four windows:
- one window above 4 GB;
- one window covering the frame buffer;
- one disabled through the low fields;
- one disabled through the high fields.

Each combination is checked against about twenty addresses, in both directions and for both access types. The addresses include both window edges and their neighbours, the frame buffer edges, the display port edges, aliases of those ports, and addresses with bits set above bit 15.

// File: rtl/bfwd_pkg.sv
package bfwd_pkg;

    localparam int GRAN_SHIFT = 20;
    localparam int LO_W       = 12;
    localparam int HI_W       = 32;
    localparam int ADDR_W     = HI_W + LO_W + GRAN_SHIFT;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 3;

    localparam int IO_ALIAS_W = 10;
    localparam int IO_SPACE_W = 16;
    localparam int IO_RANGES  = 2;

    localparam logic [IO_ALIAS_W-1:0] IO_LO [IO_RANGES] = '{10'h3B0, 10'h3C0};
    localparam logic [IO_ALIAS_W-1:0] IO_HI [IO_RANGES] = '{10'h3BB, 10'h3DF};

    localparam logic [ADDR_W-1:0] FB_LO = 64'h0000_0000_000A_0000;
    localparam logic [ADDR_W-1:0] FB_HI = 64'h0000_0000_000B_FFFF;

    localparam int CMD_IO_BIT  = 0;
    localparam int CMD_MEM_BIT = 1;
    localparam int CMD_MST_BIT = 2;
    localparam int BCTL_LEG_BIT = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD      = 3'd0,
        SEL_BCTL     = 3'd1,
        SEL_BASE_LO  = 3'd2,
        SEL_LIMIT_LO = 3'd3,
        SEL_BASE_HI  = 3'd4,
        SEL_LIMIT_HI = 3'd5
    } reg_sel_e;

    typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

    typedef struct packed {
        logic io_en;
        logic mem_en;
        logic master_en;
    } cmd_t;

    typedef struct packed {
        cmd_t            cmd;
        logic            legacy_en;
        logic [LO_W-1:0] base_lo;
        logic [LO_W-1:0] limit_lo;
        logic [HI_W-1:0] base_hi;
        logic [HI_W-1:0] limit_hi;
    } cfg_t;

    typedef struct packed {
        logic win_en;
        logic win_hit;
        logic fb_hit;
        logic port_hit;
    } match_t;

    function automatic logic [ADDR_W-1:0] full_base(input cfg_t c);
        return {c.base_hi, c.base_lo, {GRAN_SHIFT{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] full_limit(input cfg_t c);
        return {c.limit_hi, c.limit_lo, {GRAN_SHIFT{1'b1}}};
    endfunction

endpackage

// File: rtl/bfwd_cfg_regs.sv
module bfwd_cfg_regs
    import bfwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o
);

    cfg_t cfg_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.cmd       <= '0;
            cfg_q.legacy_en <= 1'b0;
            cfg_q.base_lo   <= '1;
            cfg_q.base_hi   <= '1;
            cfg_q.limit_lo  <= '0;
            cfg_q.limit_hi  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CMD: begin
                    cfg_q.cmd.io_en     <= wr_data[CMD_IO_BIT];
                    cfg_q.cmd.mem_en    <= wr_data[CMD_MEM_BIT];
                    cfg_q.cmd.master_en <= wr_data[CMD_MST_BIT];
                end
                SEL_BCTL:     cfg_q.legacy_en <= wr_data[BCTL_LEG_BIT];
                SEL_BASE_LO:  cfg_q.base_lo   <= wr_data[LO_W-1:0];
                SEL_LIMIT_LO: cfg_q.limit_lo  <= wr_data[LO_W-1:0];
                SEL_BASE_HI:  cfg_q.base_hi   <= wr_data[HI_W-1:0];
                SEL_LIMIT_HI: cfg_q.limit_hi  <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/bfwd_win_cmp.sv
module bfwd_win_cmp
    import bfwd_pkg::*;
(
    input  cfg_t              cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              win_en_o,
    output logic              win_hit_o
);

    logic [ADDR_W-1:0] lo_bound;
    logic [ADDR_W-1:0] hi_bound;
    logic              above_lo;
    logic              below_hi;

    always_comb begin
        lo_bound  = full_base(cfg_i);
        hi_bound  = full_limit(cfg_i);
        win_en_o  = (lo_bound <= hi_bound);
        above_lo  = (addr_i >= lo_bound);
        below_hi  = (addr_i <= hi_bound);
        win_hit_o = win_en_o && above_lo && below_hi;
    end

endmodule

// File: rtl/bfwd_legacy_match.sv
module bfwd_legacy_match
    import bfwd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fb_hit_o,
    output logic              port_hit_o
);

    logic [IO_RANGES-1:0] range_hit;
    logic [IO_ALIAS_W-1:0] alias_bits;
    logic                  upper_zero;

    assign alias_bits = addr_i[IO_ALIAS_W-1:0];
    assign upper_zero = (addr_i[ADDR_W-1:IO_SPACE_W] == '0);

    for (genvar g = 0; g < IO_RANGES; g++) begin : g_port
        assign range_hit[g] = (alias_bits >= IO_LO[g]) && (alias_bits <= IO_HI[g]);
    end

    assign port_hit_o = upper_zero && (|range_hit);
    assign fb_hit_o   = (addr_i >= FB_LO) && (addr_i <= FB_HI);

endmodule

// File: rtl/bfwd_policy.sv
module bfwd_policy
    import bfwd_pkg::*;
(
    input  dir_e   dir_i,
    input  logic   is_io_i,
    input  cfg_t   cfg_i,
    input  match_t m_i,
    output logic   fwd_o
);

    logic leg_fb;
    logic leg_port;

    always_comb begin
        leg_fb   = cfg_i.legacy_en && m_i.fb_hit;
        leg_port = cfg_i.legacy_en && m_i.port_hit;
        fwd_o    = 1'b0;
        unique case (dir_i)
            DIR_DOWN: begin
                if (is_io_i)
                    fwd_o = leg_port && cfg_i.cmd.io_en;
                else
                    fwd_o = cfg_i.cmd.mem_en && (m_i.win_hit || leg_fb);
            end
            DIR_UP: begin
                if (is_io_i)
                    fwd_o = cfg_i.cmd.master_en && !m_i.port_hit;
                else
                    fwd_o = cfg_i.cmd.master_en && !m_i.win_hit && !leg_fb;
            end
            default: fwd_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bfwd_decoder.sv
module bfwd_decoder
    import bfwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              txn_valid,
    input  logic              txn_dir,
    input  logic              txn_is_io,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic              dec_valid,
    output logic              dec_forward
);

    cfg_t   cfg_q;
    match_t match;
    logic   fwd_comb;

    bfwd_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg_q)
    );

    bfwd_win_cmp u_win (
        .cfg_i     (cfg_q),
        .addr_i    (txn_addr),
        .win_en_o  (match.win_en),
        .win_hit_o (match.win_hit)
    );

    bfwd_legacy_match u_leg (
        .addr_i     (txn_addr),
        .fb_hit_o   (match.fb_hit),
        .port_hit_o (match.port_hit)
    );

    bfwd_policy u_pol (
        .dir_i   (dir_e'(txn_dir)),
        .is_io_i (txn_is_io),
        .cfg_i   (cfg_q),
        .m_i     (match),
        .fwd_o   (fwd_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid   <= 1'b0;
            dec_forward <= 1'b0;
        end else begin
            dec_valid   <= txn_valid;
            dec_forward <= txn_valid && fwd_comb;
        end
    end

endmodule

// File: rtl/bfwd_checker.sv
module bfwd_checker
    import bfwd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              txn_valid,
    input logic              txn_dir,
    input logic              txn_is_io,
    input logic [ADDR_W-1:0] txn_addr,
    input cfg_t              cfg_q,
    input logic              dec_valid,
    input logic              dec_forward
);

    logic port_like;
    assign port_like = (txn_addr[ADDR_W-1:16] == '0) &&
        (((txn_addr[9:0] >= 10'h3B0) && (txn_addr[9:0] <= 10'h3BB)) ||
         ((txn_addr[9:0] >= 10'h3C0) && (txn_addr[9:0] <= 10'h3DF)));

    logic fb_like;
    assign fb_like = (txn_addr >= 64'hA0000) && (txn_addr <= 64'hBFFFF);

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> dec_valid); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> (!dec_valid && !dec_forward)); // R2

    AST_PORT_NEVER_UP: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_dir && txn_is_io && port_like) |=> !dec_forward); // R11

    AST_UP_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_dir && !cfg_q.cmd.master_en) |=> !dec_forward); // R7

    AST_DOWN_IO_NEEDS_LEGACY: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_dir && txn_is_io && !cfg_q.legacy_en) |=> !dec_forward); // R11

    AST_FB_BLOCKED_UP: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_dir && !txn_is_io && fb_like && cfg_q.legacy_en) |=> !dec_forward); // R9

    AST_DOWN_MEM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_dir && !txn_is_io && !cfg_q.cmd.mem_en) |=> !dec_forward); // R6

endmodule

bind bfwd_decoder bfwd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .txn_valid   (txn_valid),
    .txn_dir     (txn_dir),
    .txn_is_io   (txn_is_io),
    .txn_addr    (txn_addr),
    .cfg_q       (cfg_q),
    .dec_valid   (dec_valid),
    .dec_forward (dec_forward)
);

// File: tb/tb_bfwd_decoder.sv
module tb_bfwd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        txn_valid = 1'b0;
    logic        txn_dir = 1'b0;
    logic        txn_is_io = 1'b0;
    logic [63:0] txn_addr = '0;
    logic        dec_valid;
    logic        dec_forward;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench-side model of the configuration
    bit        m_io, m_mem, m_mst, m_leg;
    bit [11:0] m_blo, m_llo;
    bit [31:0] m_bhi, m_lhi;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfwd_decoder dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .txn_valid(txn_valid), .txn_dir(txn_dir), .txn_is_io(txn_is_io),
        .txn_addr(txn_addr), .dec_valid(dec_valid), .dec_forward(dec_forward)
    );

    task automatic check(input string tag, input logic act, input logic exp, input logic [63:0] a);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cmd(input bit io, input bit mem, input bit mst, input bit leg);
        wr(3'd0, {29'd0, mst, mem, io});
        wr(3'd1, {28'd0, leg, 3'd0});
        m_io = io; m_mem = mem; m_mst = mst; m_leg = leg;
    endtask

    task automatic set_win(input bit [31:0] bhi, input bit [11:0] blo,
                           input bit [31:0] lhi, input bit [11:0] llo);
        wr(3'd2, {20'd0, blo});
        wr(3'd3, {20'd0, llo});
        wr(3'd4, bhi);
        wr(3'd5, lhi);
        m_bhi = bhi; m_blo = blo; m_lhi = lhi; m_llo = llo;
    endtask

    function automatic bit [63:0] mbase();
        return {m_bhi, m_blo, 20'h00000};
    endfunction

    function automatic bit [63:0] mlimit();
        return {m_lhi, m_llo, 20'hFFFFF};
    endfunction

    function automatic bit is_port(input bit [63:0] a);
        return (a[63:16] == 0) &&
               ((a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) ||
                (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF));
    endfunction

    function automatic bit is_fb(input bit [63:0] a);
        return a >= 64'hA0000 && a <= 64'hBFFFF;
    endfunction

    function automatic bit exp_fwd(input bit dir, input bit io, input bit [63:0] a);
        bit inwin;
        inwin = (mbase() <= mlimit()) && a >= mbase() && a <= mlimit();
        if (!dir) begin
            if (io) return m_leg && is_port(a) && m_io;
            return m_mem && (inwin || (m_leg && is_fb(a)));
        end
        if (io) return m_mst && !is_port(a);
        return m_mst && !inwin && !(m_leg && is_fb(a));
    endfunction

    function automatic string tag_of(input bit dir, input bit io, input bit [63:0] a);
        if (io) return (is_port(a) && !dir) ? "R10" : "R11";
        if (is_fb(a)) return m_leg ? (dir ? "R9" : "R8") : "R12";
        if (mbase() > mlimit()) return "R5";
        if (a == mbase() || a == mlimit() || a == mbase() - 1 || a == mlimit() + 1) return "R4";
        return dir ? "R7" : "R6";
    endfunction

    task automatic txn(input string tag, input bit dir, input bit io,
                       input bit [63:0] a, input bit exp);
        @(negedge clk);
        txn_valid = 1'b1; txn_dir = dir; txn_is_io = io; txn_addr = a;
        @(negedge clk);
        txn_valid = 1'b0;
        check("R2", dec_valid, 1'b1, a);
        check(tag, dec_forward, exp, a);
    endtask

    function automatic bit [63:0] addr_at(input int i);
        case (i)
            0:  return 64'h0;
            1:  return 64'h9FFFF;
            2:  return 64'hA0000;
            3:  return 64'hABCDE;
            4:  return 64'hBFFFF;
            5:  return 64'hC0000;
            6:  return 64'h3AF;
            7:  return 64'h3B0;
            8:  return 64'h3BB;
            9:  return 64'h3BC;
            10: return 64'h3BF;
            11: return 64'h3C0;
            12: return 64'h3DF;
            13: return 64'h3E0;
            14: return 64'h7FB5;
            15: return 64'hFFD0;
            16: return 64'h1_03C0;
            17: return 64'h1_0000_03B0;
            18: return mbase() - 1;
            19: return mbase();
            20: return mlimit();
            default: return mlimit() + 1;
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_io = 0; m_mem = 0; m_mst = 0; m_leg = 0;
        m_bhi = 32'hFFFFFFFF; m_blo = 12'hFFF; m_lhi = 0; m_llo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check("R1", dec_valid, 1'b0, 64'h0);
        check("R1", dec_forward, 1'b0, 64'h0);
        txn("R1", 1'b1, 1'b1, 64'h1000, 1'b0);
        txn("R1", 1'b0, 1'b0, 64'h0, 1'b0);

        // R1 / R5: window disabled after reset even with enables on
        set_cmd(1, 1, 1, 0);
        txn("R1", 1'b0, 1'b0, 64'h0, 1'b0);
        txn("R1", 1'b0, 1'b0, 64'hFFFF_FFFF_FFF0_0000, 1'b0);
        txn("R5", 1'b1, 1'b0, 64'h0, 1'b1);

        // R2: idle cycle gives quiet outputs
        @(negedge clk);
        check("R2", dec_valid, 1'b0, 64'h0);
        check("R2", dec_forward, 1'b0, 64'h0);

        // R3: write port encodings
        set_cmd(0, 1, 0, 0);
        set_win(32'h1, 12'h001, 32'h1, 12'h003);
        txn("R3", 1'b0, 1'b0, 64'h1_0010_0000, 1'b1);
        txn("R3", 1'b1, 1'b0, 64'h0, 1'b0);
        set_cmd(1, 0, 0, 1);
        txn("R3", 1'b0, 1'b1, 64'h3C0, 1'b1);
        txn("R3", 1'b0, 1'b0, 64'h1_0010_0000, 1'b0);

        // sweep: windows x enables x addresses x direction x type
        for (int w = 0; w < 4; w++) begin
            case (w)
                0: set_win(32'h1, 12'h001, 32'h1, 12'h003);
                1: set_win(32'h0, 12'h000, 32'h0, 12'h000);
                2: set_win(32'h0, 12'h002, 32'h0, 12'h001);
                default: set_win(32'h2, 12'h000, 32'h1, 12'hFFF);
            endcase
            for (int c = 0; c < 16; c++) begin
                set_cmd(c[0], c[1], c[2], c[3]);
                for (int i = 0; i < 22; i++) begin
                    for (int k = 0; k < 4; k++) begin
                        bit [63:0] a;
                        a = addr_at(i);
                        txn(tag_of(k[0], k[1], a), k[0], k[1], a, exp_fwd(k[0], k[1], a));
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule